// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits beside the CPU byte bus of a handheld console and turns CPU writes that land in the ROM address range into control commands. From those commands it keeps a ROM bank number, an external-RAM bank number, a RAM gate and a clock-register selection. It drives a banked ROM byte address for both ROM windows and a banked RAM byte address for the external window at 0xA000-0xBFFF. It also decides what the external window answers: a clock register, the RAM byte, or the idle value 0xFF.

The clock registers are a small local file. Timekeeping happens outside the block, which only sees a live snapshot of seconds, minutes, hours and a 9-bit day count. A write of 0x00 and then 0x01 to the latch range copies that snapshot into the file. The frozen values stay there until the next complete latch sequence or until a write through the window changes them. The latch handshake is a two-state machine. `LATCH_IDLE` takes the ARM transition to `LATCH_ARMED` when a latch-range write carries 0x00. `LATCH_ARMED` takes the FIRE transition back to `LATCH_IDLE` on 0x01, and that transition emits the copy pulse. Any other latch-range value takes the DISARM transition to `LATCH_IDLE`. A repeated 0x00 keeps the machine in `LATCH_ARMED`.

Control writes take effect from the clock edge that captures them. The address outputs and the window read data are combinational in the CPU address.

Top module: `cart_bank_ctrl`

## Requirements
- R1: For CPU addresses 0x0000-0x3FFF, `rom_addr` equals the address bits 13:0 with all bank bits zero.
- R2: For CPU addresses 0x4000-0x7FFF, `rom_addr` is the effective ROM bank in bits above 14, concatenated with address bits 13:0.
- R3: A write of 0x0A in 0x0000-0x1FFF opens the RAM gate and a write of 0x00 there closes it. Every other value leaves the gate as it was.
- R4: A write in 0x2000-0x3FFF loads the ROM bank from data bits 6:0. Bit 7 is ignored, and a resulting 0 is stored as 1.
- R5: The effective ROM bank is the stored bank modulo the ROM_BANKS parameter (8 by default).
- R6: A write of a value below RAM_BANKS (4 by default) in 0x4000-0x5FFF selects that RAM bank and leaves clock mode. `ram_addr` is {RAM bank, address bits 12:0}.
- R7: A write of 0x08-0x0C in 0x4000-0x5FFF enters clock mode and selects clock register (value - 8). Values 0x04-0x07 and 0x0D-0xFF change nothing.
- R8: A window read returns the selected clock register in clock mode. Otherwise it returns `ram_rdata` when the gate is open, and 0xFF when it is not.
- R9: A window write updates the selected clock register in clock mode and does not raise `ram_we`. Otherwise it raises `ram_we` only when the gate is open, and it is ignored when the gate is closed.
- R10: Clock registers 0 to 4 hold seconds, minutes, hours, day bits 7:0 and a flag byte. A latch puts day bit 8 in flag bit 0 and keeps flag bits 7:1.
- R11: Only a 0x00 write followed by a 0x01 write in 0x6000-0x7FFF latches. Writes to other ranges do not disturb the sequence, and without a latch the registers do not follow the live inputs.
- R12: After reset the ROM bank is 1, the RAM bank is 0, the gate is closed, clock mode is off and all clock registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| rom_addr | output | 17 | Banked ROM byte address (ROM_AW) |
| ram_addr | output | 15 | Banked external-RAM byte address (RAM_AW) |
| ram_we | output | 1 | External-RAM write enable |
| ram_wdata | output | 8 | External-RAM write data |
| ram_rdata | input | 8 | External-RAM read data |
| ext_rdata | output | 8 | Data answered for the 0xA000-0xBFFF window, 0xFF elsewhere |
| live_sec | input | 8 | Live seconds snapshot |
| live_min | input | 8 | Live minutes snapshot |
| live_hour | input | 8 | Live hours snapshot |
| live_day | input | 9 | Live day counter |

## Verification
The FIRE write and a change of the live clock inputs can fall in the same cycle. The bench changes the snapshot at the same falling edge where it drives the 0x01 latch write. It then changes the snapshot again one cycle later. It judges the result by reading every clock register back through the window. Each register must hold the value that was present at the capturing edge, and none may hold the earlier or the later value. The flag byte is also judged with day bit 8 set and then clear, on top of upper flag bits that were written through the window beforehand.

// File: rtl/cart_pkg.sv
package cart_pkg;

    localparam int CLK_REGS   = 5;
    localparam int CLK_SEL_W  = 3;
    localparam int FLAG_IDX   = CLK_REGS - 1;

    typedef enum logic [2:0] {
        CR_RAM_GATE = 3'd0,
        CR_ROM_SEL  = 3'd1,
        CR_RAM_SEL  = 3'd2,
        CR_LATCH    = 3'd3,
        CR_NONE     = 3'd4
    } ctrl_region_t;

    typedef enum logic [0:0] {
        LATCH_IDLE  = 1'b0,
        LATCH_ARMED = 1'b1
    } latch_state_t;

    typedef enum logic [1:0] {
        WIN_CLOCK = 2'd0,
        WIN_RAM   = 2'd1,
        WIN_FLOAT = 2'd2,
        WIN_OUT   = 2'd3
    } win_src_t;

endpackage

// File: rtl/cart_reg_decode.sv
module cart_reg_decode
    import cart_pkg::*;
#(
    parameter int RAM_BANKS  = 4,
    parameter int RAM_BANK_W = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            addr_hi,
    input  logic [7:0]            wdata,
    input  logic                  we,
    output logic [6:0]            rom_sel,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en,
    output logic                  clk_mode,
    output logic [CLK_SEL_W-1:0]  clk_sel,
    output logic                  latch_pulse
);

    localparam logic [7:0] GATE_OPEN  = 8'h0A;
    localparam logic [7:0] GATE_SHUT  = 8'h00;
    localparam logic [7:0] CLK_FIRST  = 8'h08;
    localparam logic [7:0] CLK_LAST   = 8'(8 + CLK_REGS - 1);
    localparam logic [7:0] RAM_LIMIT  = 8'(RAM_BANKS);

    ctrl_region_t region;
    latch_state_t state_q, state_d;

    always_comb begin
        if (addr_hi[2]) region = CR_NONE;
        else            region = ctrl_region_t'({1'b0, addr_hi[1:0]});
    end

    // control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_sel  <= 7'd1;
            ram_bank <= '0;
            ram_en   <= 1'b0;
            clk_mode <= 1'b0;
            clk_sel  <= '0;
        end else if (we) begin
            unique case (region)
                CR_RAM_GATE: begin
                    if (wdata == GATE_OPEN)      ram_en <= 1'b1;
                    else if (wdata == GATE_SHUT) ram_en <= 1'b0;
                end
                CR_ROM_SEL: begin
                    rom_sel <= (wdata[6:0] == 7'd0) ? 7'd1 : wdata[6:0];
                end
                CR_RAM_SEL: begin
                    if (wdata < RAM_LIMIT) begin
                        ram_bank <= RAM_BANK_W'(wdata);
                        clk_mode <= 1'b0;
                    end else if (wdata >= CLK_FIRST && wdata <= CLK_LAST) begin
                        clk_mode <= 1'b1;
                        clk_sel  <= CLK_SEL_W'(wdata - CLK_FIRST);
                    end
                end
                CR_LATCH, CR_NONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // latch handshake: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LATCH_IDLE;
        else        state_q <= state_d;
    end

    // latch handshake: next state
    always_comb begin
        state_d = state_q;
        if (we && region == CR_LATCH) begin
            unique case (state_q)
                LATCH_IDLE:  state_d = (wdata == 8'h00) ? LATCH_ARMED : LATCH_IDLE;
                LATCH_ARMED: state_d = (wdata == 8'h00) ? LATCH_ARMED : LATCH_IDLE;
                default:     state_d = LATCH_IDLE;
            endcase
        end
    end

    // latch handshake: outputs
    always_comb begin
        latch_pulse = 1'b0;
        unique case (state_q)
            LATCH_IDLE:  latch_pulse = 1'b0;
            LATCH_ARMED: latch_pulse = we && (region == CR_LATCH) && (wdata == 8'h01);
            default:     latch_pulse = 1'b0;
        endcase
    end

    assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && region == CR_RAM_GATE && wdata != GATE_OPEN && wdata != GATE_SHUT)
        |=> $stable(ram_en));

    assert_rom_zero_fix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && region == CR_ROM_SEL && wdata[6:0] == 7'd0) |=> (rom_sel == 7'd1));

    assert_clk_sel_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clk_mode |-> (clk_sel <= CLK_SEL_W'(CLK_REGS - 1)));

    assert_no_idle_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LATCH_IDLE) |-> !latch_pulse);

endmodule

// File: rtl/cart_clock_file.sv
module cart_clock_file
    import cart_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 latch,
    input  logic                 wr_en,
    input  logic [CLK_SEL_W-1:0] sel,
    input  logic [7:0]           wr_data,
    input  logic [7:0]           live_sec,
    input  logic [7:0]           live_min,
    input  logic [7:0]           live_hour,
    input  logic [8:0]           live_day,
    output logic [7:0]           rd_data
);

    logic [FLAG_IDX-1:0][7:0] snap;
    logic [7:0]               regs_q [CLK_REGS];
    logic [CLK_REGS-1:0][7:0] regs_view;

    assign snap = {live_day[7:0], live_hour, live_min, live_sec};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CLK_REGS; i++) regs_q[i] <= 8'h00;
        end else if (latch) begin
            for (int i = 0; i < FLAG_IDX; i++) regs_q[i] <= snap[i];
            regs_q[FLAG_IDX] <= {regs_q[FLAG_IDX][7:1], live_day[8]};
        end else if (wr_en && int'(sel) < CLK_REGS) begin
            regs_q[sel] <= wr_data;
        end
    end

    for (genvar g = 0; g < CLK_REGS; g++) begin : g_view
        assign regs_view[g] = regs_q[g];
    end

    assign rd_data = (int'(sel) < CLK_REGS) ? regs_q[sel] : 8'hFF;

    assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch && !wr_en) |=> $stable(regs_view));

    assert_latch_copy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (regs_view[0] == $past(live_sec) &&
                   regs_view[FLAG_IDX][0] == $past(live_day[8]) &&
                   regs_view[FLAG_IDX][7:1] == $past(regs_view[FLAG_IDX][7:1])));

endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
    import cart_pkg::*;
#(
    parameter int ROM_BANKS  = 8,
    parameter int RAM_BANK_W = 2,
    parameter int ROM_BANK_W = $clog2(ROM_BANKS),
    parameter int ROM_AW     = ROM_BANK_W + 14,
    parameter int RAM_AW     = RAM_BANK_W + 13
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           cpu_addr,
    input  logic                  cpu_we,
    input  logic [7:0]            cpu_wdata,
    input  logic [6:0]            rom_sel,
    input  logic [RAM_BANK_W-1:0] ram_bank,
    input  logic                  ram_en,
    input  logic                  clk_mode,
    input  logic [7:0]            clk_rdata,
    input  logic [7:0]            ram_rdata,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic                  ram_we,
    output logic [7:0]            ram_wdata,
    output logic                  clk_we,
    output logic [7:0]            ext_rdata
);

    logic [ROM_BANK_W-1:0] bank_eff;
    logic                  in_window;
    win_src_t              src;

    assign bank_eff  = ROM_BANK_W'({25'd0, rom_sel} % ROM_BANKS);
    assign in_window = (cpu_addr[15:13] == 3'b101);

    always_comb begin
        if (cpu_addr[14]) rom_addr = {bank_eff, cpu_addr[13:0]};
        else              rom_addr = {{ROM_BANK_W{1'b0}}, cpu_addr[13:0]};
    end

    assign ram_addr  = {ram_bank, cpu_addr[12:0]};
    assign ram_wdata = cpu_wdata;

    always_comb begin
        if (!in_window)    src = WIN_OUT;
        else if (clk_mode) src = WIN_CLOCK;
        else if (ram_en)   src = WIN_RAM;
        else               src = WIN_FLOAT;
    end

    always_comb begin
        ext_rdata = 8'hFF;
        ram_we    = 1'b0;
        clk_we    = 1'b0;
        unique case (src)
            WIN_CLOCK: begin
                ext_rdata = clk_rdata;
                clk_we    = cpu_we;
            end
            WIN_RAM: begin
                ext_rdata = ram_rdata;
                ram_we    = cpu_we;
            end
            WIN_FLOAT: ext_rdata = 8'hFF;
            WIN_OUT:   ext_rdata = 8'hFF;
            default:   ext_rdata = 8'hFF;
        endcase
    end

    assert_low_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:14] == '0));

    assert_upper_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> (rom_addr[ROM_AW-1:14] != '0 || rom_sel[ROM_BANK_W-1:0] == '0));

    assert_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && !clk_mode && !ram_en) |-> (ext_rdata == 8'hFF));

    assert_clock_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_window && clk_mode) |-> (ext_rdata == clk_rdata && !ram_we));

    assert_ram_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_en && !clk_mode && cpu_we && in_window));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_pkg::*;
#(
    parameter int ROM_BANKS  = 8,
    parameter int RAM_BANKS  = 4,
    parameter int ROM_BANK_W = $clog2(ROM_BANKS),
    parameter int RAM_BANK_W = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1,
    parameter int ROM_AW     = ROM_BANK_W + 14,
    parameter int RAM_AW     = RAM_BANK_W + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_we,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata,
    output logic [7:0]        ext_rdata,
    input  logic [7:0]        live_sec,
    input  logic [7:0]        live_min,
    input  logic [7:0]        live_hour,
    input  logic [8:0]        live_day
);

    logic [6:0]            rom_sel;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  ram_en;
    logic                  clk_mode;
    logic [CLK_SEL_W-1:0]  clk_sel;
    logic                  latch_pulse;
    logic                  clk_we;
    logic [7:0]            clk_rdata;

    cart_reg_decode #(
        .RAM_BANKS  (RAM_BANKS),
        .RAM_BANK_W (RAM_BANK_W)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_hi     (cpu_addr[15:13]),
        .wdata       (cpu_wdata),
        .we          (cpu_we),
        .rom_sel     (rom_sel),
        .ram_bank    (ram_bank),
        .ram_en      (ram_en),
        .clk_mode    (clk_mode),
        .clk_sel     (clk_sel),
        .latch_pulse (latch_pulse)
    );

    cart_clock_file u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch     (latch_pulse),
        .wr_en     (clk_we),
        .sel       (clk_sel),
        .wr_data   (cpu_wdata),
        .live_sec  (live_sec),
        .live_min  (live_min),
        .live_hour (live_hour),
        .live_day  (live_day),
        .rd_data   (clk_rdata)
    );

    cart_addr_map #(
        .ROM_BANKS  (ROM_BANKS),
        .RAM_BANK_W (RAM_BANK_W),
        .ROM_BANK_W (ROM_BANK_W),
        .ROM_AW     (ROM_AW),
        .RAM_AW     (RAM_AW)
    ) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .cpu_wdata (cpu_wdata),
        .rom_sel   (rom_sel),
        .ram_bank  (ram_bank),
        .ram_en    (ram_en),
        .clk_mode  (clk_mode),
        .clk_rdata (clk_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .clk_we    (clk_we),
        .ext_rdata (ext_rdata)
    );

endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
module cart_bank_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ROM_AW = 17;
    localparam int RAM_AW = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = 16'h0000;
    logic [7:0]        cpu_wdata = 8'h00;
    logic              cpu_we = 1'b0;
    logic [ROM_AW-1:0] rom_addr;
    logic [RAM_AW-1:0] ram_addr;
    logic              ram_we;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata;
    logic [7:0]        ext_rdata;
    logic [7:0]        live_sec = 8'h00;
    logic [7:0]        live_min = 8'h00;
    logic [7:0]        live_hour = 8'h00;
    logic [8:0]        live_day = 9'h000;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;

    // model state
    int  m_rom = 1;
    bit  m_en = 0;
    int  m_rbank = 0;
    bit  m_clk = 0;
    int  m_sel = 0;
    bit  m_armed = 0;
    logic [7:0] m_regs [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: content is a function of the address
    assign ram_rdata = ram_addr[7:0] ^ {1'b0, ram_addr[14:8]};

    cart_bank_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_we    (cpu_we),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata),
        .ext_rdata (ext_rdata),
        .live_sec  (live_sec),
        .live_min  (live_min),
        .live_hour (live_hour),
        .live_day  (live_day)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] mem_at(input int bank, input logic [15:0] a);
        logic [14:0] ra;
        ra = {2'(bank), a[12:0]};
        return ra[7:0] ^ {1'b0, ra[14:8]};
    endfunction

    function automatic logic [7:0] exp_win(input logic [15:0] a);
        if (m_clk)     return m_regs[m_sel];
        else if (m_en) return mem_at(m_rbank, a);
        else           return 8'hFF;
    endfunction

    task automatic model(input logic [15:0] a, input logic [7:0] d);
        if (a[15:13] == 3'd0) begin
            if (d == 8'h0A) m_en = 1;
            else if (d == 8'h00) m_en = 0;
        end else if (a[15:13] == 3'd1) begin
            m_rom = (d[6:0] == 0) ? 1 : int'(d[6:0]);
        end else if (a[15:13] == 3'd2) begin
            if (d < 4) begin m_rbank = d; m_clk = 0; end
            else if (d >= 8 && d <= 8'h0C) begin m_clk = 1; m_sel = d - 8; end
        end else if (a[15:13] == 3'd3) begin
            if (m_armed && d == 8'h01) begin
                m_regs[0] = live_sec; m_regs[1] = live_min; m_regs[2] = live_hour;
                m_regs[3] = live_day[7:0];
                m_regs[4] = {m_regs[4][7:1], live_day[8]};
            end
            m_armed = (d == 8'h00);
        end else if (a[15:13] == 3'b101 && m_clk) begin
            m_regs[m_sel] = d;
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        model(a, d);
    endtask

    task automatic rd_check(input string req, input logic [15:0] a);
        cpu_addr = a;
        #1;
        check(req, ext_rdata, exp_win(a));
    endtask

    task automatic check_all_clock(input string req);
        for (int r = 0; r < 5; r++) begin
            wr(16'h4000, 8'(8 + r));
            rd_check(req, 16'hA000);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 5; r++) m_regs[r] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        cpu_addr = 16'h4000; #1;
        check("R12 rom bank", rom_addr, {3'd1, 14'h0000});
        cpu_addr = 16'hA123; #1;
        check("R12 window idle", ext_rdata, 8'hFF);
        check("R12 ram bank", ram_addr, {2'd0, 13'h0123});
        check("R12 ram_we", ram_we, 0);

        // R1 fixed lower window
        for (int a = 0; a < 16'h4000; a += 16'h0353) begin
            cpu_addr = 16'(a); #1;
            check("R1 lower window", rom_addr, {3'd0, 14'(a)});
        end

        // R2 R4 R5 bank sweep over all data values
        for (int v = 0; v < 256; v++) begin
            wr(16'h2000 + 16'(v * 31 % 8192), 8'(v));
            cpu_addr = 16'h4000 + 16'(v * 57 % 16384); #1;
            check("R4 R5 upper window bank", rom_addr,
                  {3'(m_rom % 8), 14'(v * 57 % 16384)});
            cpu_addr = 16'h1234; #1;
            check("R1 lower stays bank 0", rom_addr, 17'h01234);
        end

        // R3 gate sweep; R8 reads follow the gate
        wr(16'h4000, 8'h02);
        for (int v = 0; v < 256; v++) begin
            wr(16'h0000 + 16'(v * 29 % 8192), 8'(v));
            rd_check("R3 R8 gate", 16'hA000 + 16'(v));
            if (v % 16 == 0) begin
                wr(16'h1FFF, 8'h0A);
                rd_check("R3 gate open", 16'hB00F);
            end
        end

        // preload clock registers through a latch
        live_sec = 8'h11; live_min = 8'h22; live_hour = 8'h33; live_day = 9'h144;
        wr(16'h6000, 8'h00);
        wr(16'h7FFF, 8'h01);
        wr(16'h0000, 8'h0A);

        // R6 R7 R8 sweep of the RAM/clock select range
        for (int v = 0; v < 256; v++) begin
            wr(16'h4000 + 16'(v * 13 % 8192), 8'(v));
            rd_check("R6 R7 R8 select", 16'hA005);
            if (!m_clk) check("R6 ram_addr", ram_addr, {2'(m_rbank), 13'h0005});
        end

        // R9 window writes
        wr(16'h4000, 8'h01);
        @(negedge clk);
        cpu_addr = 16'hA7F0; cpu_wdata = 8'h5C; cpu_we = 1'b1; #1;
        check("R9 ram_we when open", ram_we, 1);
        check("R9 ram_addr on write", ram_addr, {2'd1, 13'h07F0});
        check("R9 ram_wdata", ram_wdata, 8'h5C);
        @(negedge clk); cpu_we = 1'b0;
        wr(16'h0000, 8'h00);
        @(negedge clk);
        cpu_addr = 16'hA7F0; cpu_wdata = 8'h5C; cpu_we = 1'b1; #1;
        check("R9 ignored when closed", ram_we, 0);
        @(negedge clk); cpu_we = 1'b0;
        rd_check("R9 closed read", 16'hA7F0);
        wr(16'h4000, 8'h0C);
        @(negedge clk);
        cpu_addr = 16'hBFFF; cpu_wdata = 8'hF6; cpu_we = 1'b1; #1;
        check("R9 clock write keeps ram_we low", ram_we, 0);
        @(negedge clk); cpu_we = 1'b0;
        model(16'hBFFF, 8'hF6);
        rd_check("R9 flag written", 16'hA000);

        // R10 latch layout with concurrent live change
        live_sec = 8'h01; live_min = 8'h02; live_hour = 8'h03; live_day = 9'h1AB;
        wr(16'h6000, 8'h00);
        @(negedge clk);
        cpu_addr = 16'h6000; cpu_wdata = 8'h01; cpu_we = 1'b1;
        live_sec = 8'h41; live_min = 8'h42; live_hour = 8'h13; live_day = 9'h1C7;
        @(negedge clk);
        cpu_we = 1'b0;
        model(16'h6000, 8'h01);
        live_sec = 8'h55; live_min = 8'h56; live_hour = 8'h17; live_day = 9'h0EE;
        check_all_clock("R10 latch at capturing edge");
        wr(16'h4000, 8'h0C);
        rd_check("R10 flag bit0 set", 16'hA000);
        check("R10 flag value", ext_rdata, 8'hF7);
        wr(16'h6000, 8'h00);
        wr(16'h6000, 8'h01);
        wr(16'h4000, 8'h0C);
        rd_check("R10 flag bit0 clear", 16'hA000);
        check("R10 flag value clear", ext_rdata, 8'hF6);

        // R11 non-latching sequences and intervening writes
        live_sec = 8'h99; live_min = 8'h98; live_hour = 8'h09; live_day = 9'h1FF;
        wr(16'h6000, 8'h01);
        check_all_clock("R11 lone 1");
        wr(16'h6000, 8'h00); wr(16'h6000, 8'h02); wr(16'h6000, 8'h01);
        check_all_clock("R11 broken by 2");
        wr(16'h6000, 8'h00); wr(16'h6000, 8'h00); wr(16'h2000, 8'h05); wr(16'h6000, 8'h01);
        check_all_clock("R11 repeated 0 and foreign write latch");
        check("R11 latched seconds", m_regs[0], 8'h99);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule